// File: doc/BRIEF.md
# DRAM Row/Column Address Sequencer with Refresh

This block connects a small processor bus to a DRAM whose 20-bit cell address must arrive over a 10-pin multiplexed address port. A read or write request is a one-cycle pulse on `cpu_rd` or `cpu_wr`. The pulse comes with the full address and, for a write, the data byte. The sequencer puts the upper address half on the pins and lowers the row strobe. After a set number of clocks it puts the lower half on the pins and lowers the column strobe. A precharge interval, with both strobes high, closes each cycle. Only one request may be outstanding at a time. `cpu_ack` pulses for one clock when the access completes, and on a read `cpu_rdata` carries the byte in that cycle.

The sequencer also owns refresh. A free-running interval timer requests a row-strobe-only refresh at a fixed clock spacing. A 10-bit row counter supplies the row to refresh and advances after each refresh. A due refresh wins over a waiting access only when the sequencer is idle. If an access request lands while a refresh or its precharge is in progress, the request is held and `cpu_wait` is raised. The held access runs as soon as the refresh finishes, and `cpu_wait` drops in the cycle its acknowledge appears.

Top module: `dram_rowcol_ctrl`

## Requirements
- R1: While `rst` is high: `dram_ras_n`, `dram_cas_n` and `dram_we_n` are 1; `dram_dq_oe`, `cpu_ack` and `cpu_wait` are 0; `dram_a` is 0.
- R2: When the row strobe falls for an access, `dram_a` equals address bits [19:10]. The address stays stable while only the row strobe is low, which lasts exactly T_RAS clocks before the column strobe falls.
- R3: When the column strobe falls, `dram_a` equals address bits [9:0]. The column strobe is low only while the row strobe is low.
- R4: Every access produces a `cpu_ack` pulse exactly one clock wide. On a read, `cpu_rdata` in that clock equals the byte the memory drove on `dram_dq_in` during the column phase.
- R5: `dram_we_n` is low only while the column strobe is low. On a write it is low during the column phase, with `dram_dq_oe` high and `dram_dq_out` equal to the write byte. It stays high for the whole of a read.
- R6: Between any two row-strobe low periods, the row strobe stays high for at least T_PRE clocks.
- R7: A refresh lowers only the row strobe; the column strobe stays high. The row strobe is held low for exactly T_REF clocks. The refreshed row comes from a counter that starts at 0 after reset, goes up by 1 with each refresh and wraps from 1023 to 0.
- R8: With no accesses pending, successive refreshes start exactly REF_INTERVAL clocks apart.
- R9: A request accepted while a refresh or its precharge is in progress raises `cpu_wait` in the next clock. `cpu_wait` stays high until the clock in which `cpu_ack` pulses, and is low in that clock. The held access starts only after the refresh ends and returns correct data.
- R10: An access that does not meet a refresh completes with `cpu_wait` low throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_rd | input | 1 | One-cycle read request pulse |
| cpu_wr | input | 1 | One-cycle write request pulse |
| cpu_addr | input | 20 | Byte address, sampled with the request |
| cpu_wdata | input | 8 | Write byte, sampled with the request |
| cpu_rdata | output | 8 | Read byte, valid when `cpu_ack` is high after a read |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_wait | output | 1 | High while a request is held behind a refresh |
| dram_a | output | 10 | Multiplexed row/column address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | 8 | Data to memory |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | 8 | Data from memory |

## Verification
On every cycle the assertions check the strobe ordering and the bus rules. The column strobe may be low only inside a row-strobe period, and write enable only inside a column phase. The row address must stay still while the row strobe alone is low. The precharge gap is never shorter than T_PRE, the acknowledge is a single pulse, and the wait line never overlaps the acknowledge. The bench scenarios show what no single-cycle property can. They check the values the address pins carry against the request, and that write data lands in a memory model and reads back. They also check the refresh spacing, the row counter stepping and wrapping, and that a request colliding with a refresh is stalled and then served.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_DATA,
    ST_PRE,
    ST_REF
  } seq_state_t;

endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
  parameter int INTERVAL = 195,
  parameter int HALF_W   = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_start,
  input  logic              ref_done,
  output logic              ref_due,
  output logic [HALF_W-1:0] ref_row
);
  localparam int TW = $clog2(INTERVAL) + 1;

  logic [TW-1:0] tmr;

  // free-running spacing timer: refresh request raised once per INTERVAL
  always_ff @(posedge clk) begin
    if (rst) begin
      tmr     <= TW'(INTERVAL - 1);
      ref_due <= 1'b0;
      ref_row <= '0;
    end else begin
      if (tmr == '0) tmr <= TW'(INTERVAL - 1);
      else           tmr <= tmr - 1'b1;

      if (tmr == '0)     ref_due <= 1'b1;
      else if (ref_start) ref_due <= 1'b0;

      if (ref_done) ref_row <= ref_row + 1'b1;
    end
  end
endmodule

// File: rtl/dram_req_hold.sv
module dram_req_hold #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_in,
  input  logic              wr_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic              take,
  output logic              pend_v,
  output logic              pend_we,
  output logic [ADDR_W-1:0] pend_addr,
  output logic [DATA_W-1:0] pend_wdata
);
  logic capture;
  assign capture = (rd_in || wr_in) && !pend_v;

  always_ff @(posedge clk) begin
    if (rst)          pend_v <= 1'b0;
    else if (take)    pend_v <= 1'b0;
    else if (capture) pend_v <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (capture) begin
      pend_we    <= wr_in;
      pend_addr  <= addr_in;
      pend_wdata <= wdata_in;
    end
  end
endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
  import dram_ctrl_pkg::*;
#(
  parameter int HALF_W = 10,
  parameter int DATA_W = 8,
  parameter int T_RAS  = 2,
  parameter int T_CAS  = 2,
  parameter int T_PRE  = 2,
  parameter int T_REF  = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ref_due,
  input  logic [HALF_W-1:0]   ref_row,
  input  logic                req_seen,
  input  logic                pend_v,
  input  logic                pend_we,
  input  logic [2*HALF_W-1:0] pend_addr,
  input  logic [DATA_W-1:0]   pend_wdata,
  output logic                take,
  output logic                ref_start,
  output logic                ref_done,
  output logic [HALF_W-1:0]   dram_a,
  output logic                ras_n,
  output logic                cas_n,
  output logic                we_n,
  output logic                dq_oe,
  output logic [DATA_W-1:0]   dq_out,
  input  logic [DATA_W-1:0]   dq_in,
  output logic [DATA_W-1:0]   rdata,
  output logic                ack,
  output logic                cpu_wait
);
  localparam int T_AB  = (T_RAS > T_CAS) ? T_RAS : T_CAS;
  localparam int T_CD  = (T_PRE > T_REF) ? T_PRE : T_REF;
  localparam int T_MAX = (T_AB > T_CD) ? T_AB : T_CD;
  localparam int CNT_W = $clog2(T_MAX + 1);

  seq_state_t          state;
  logic [CNT_W-1:0]    cnt;
  logic                ref_zone;
  logic                cur_we;
  logic [HALF_W-1:0]   cur_col;
  logic [DATA_W-1:0]   cur_wd;
  logic                cnt_zero;

  function automatic logic [CNT_W-1:0] load(input int n);
    return CNT_W'(n - 1);
  endfunction

  assign cnt_zero  = (cnt == '0);
  assign ref_start = (state == ST_IDLE) && ref_due;
  assign take      = (state == ST_IDLE) && !ref_due && pend_v;
  assign ref_done  = (state == ST_REF) && cnt_zero;
  assign dq_out    = cur_wd;

  always_ff @(posedge clk) begin
    if (take) begin
      cur_we  <= pend_we;
      cur_col <= pend_addr[HALF_W-1:0];
      cur_wd  <= pend_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      ras_n    <= 1'b1;
      cas_n    <= 1'b1;
      we_n     <= 1'b1;
      dq_oe    <= 1'b0;
      dram_a   <= '0;
      ack      <= 1'b0;
      cpu_wait <= 1'b0;
      ref_zone <= 1'b0;
      rdata    <= '0;
    end else begin
      ack <= 1'b0;
      if ((req_seen || pend_v) && (ref_zone || ref_start)) cpu_wait <= 1'b1;
      case (state)
        ST_IDLE: begin
          if (ref_start) begin
            state    <= ST_REF;
            ras_n    <= 1'b0;
            dram_a   <= ref_row;
            cnt      <= load(T_REF);
            ref_zone <= 1'b1;
          end else if (take) begin
            state  <= ST_ROW;
            ras_n  <= 1'b0;
            dram_a <= pend_addr[2*HALF_W-1:HALF_W];
            cnt    <= load(T_RAS);
          end
        end
        ST_ROW: begin
          if (cnt_zero) begin
            state  <= ST_COL;
            dram_a <= cur_col;
            cas_n  <= 1'b0;
            we_n   <= ~cur_we;
            dq_oe  <= cur_we;
            cnt    <= load(T_CAS);
          end else cnt <= cnt - 1'b1;
        end
        ST_COL: begin
          if (cnt_zero) begin
            state    <= ST_DATA;
            ack      <= 1'b1;
            cpu_wait <= 1'b0;
            if (!cur_we) rdata <= dq_in;
          end else cnt <= cnt - 1'b1;
        end
        ST_DATA: begin
          state <= ST_PRE;
          ras_n <= 1'b1;
          cas_n <= 1'b1;
          we_n  <= 1'b1;
          dq_oe <= 1'b0;
          cnt   <= load(T_PRE);
        end
        ST_PRE: begin
          if (cnt_zero) begin
            state    <= ST_IDLE;
            ref_zone <= 1'b0;
          end else cnt <= cnt - 1'b1;
        end
        ST_REF: begin
          if (cnt_zero) begin
            state <= ST_PRE;
            ras_n <= 1'b1;
            cnt   <= load(T_PRE);
          end else cnt <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dram_rowcol_ctrl.sv
module dram_rowcol_ctrl #(
  parameter int HALF_W       = 10,
  parameter int DATA_W       = 8,
  parameter int T_RAS        = 2,
  parameter int T_CAS        = 2,
  parameter int T_PRE        = 2,
  parameter int T_REF        = 3,
  parameter int REF_INTERVAL = 195
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cpu_rd,
  input  logic                cpu_wr,
  input  logic [2*HALF_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0]   cpu_wdata,
  output logic [DATA_W-1:0]   cpu_rdata,
  output logic                cpu_ack,
  output logic                cpu_wait,
  output logic [HALF_W-1:0]   dram_a,
  output logic                dram_ras_n,
  output logic                dram_cas_n,
  output logic                dram_we_n,
  output logic [DATA_W-1:0]   dram_dq_out,
  output logic                dram_dq_oe,
  input  logic [DATA_W-1:0]   dram_dq_in
);
  localparam int ADDR_W = 2 * HALF_W;

  logic              ref_due, ref_start, ref_done, take;
  logic [HALF_W-1:0] ref_row;
  logic              pend_v, pend_we;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_wdata;

  dram_refresh_timer #(.INTERVAL(REF_INTERVAL), .HALF_W(HALF_W)) u_timer (
    .clk(clk), .rst(rst), .ref_start(ref_start), .ref_done(ref_done),
    .ref_due(ref_due), .ref_row(ref_row)
  );

  dram_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .rd_in(cpu_rd), .wr_in(cpu_wr),
    .addr_in(cpu_addr), .wdata_in(cpu_wdata), .take(take),
    .pend_v(pend_v), .pend_we(pend_we), .pend_addr(pend_addr),
    .pend_wdata(pend_wdata)
  );

  dram_seq_fsm #(
    .HALF_W(HALF_W), .DATA_W(DATA_W), .T_RAS(T_RAS), .T_CAS(T_CAS),
    .T_PRE(T_PRE), .T_REF(T_REF)
  ) u_fsm (
    .clk(clk), .rst(rst), .ref_due(ref_due), .ref_row(ref_row),
    .req_seen(cpu_rd || cpu_wr), .pend_v(pend_v), .pend_we(pend_we),
    .pend_addr(pend_addr), .pend_wdata(pend_wdata), .take(take),
    .ref_start(ref_start), .ref_done(ref_done), .dram_a(dram_a),
    .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n),
    .dq_oe(dram_dq_oe), .dq_out(dram_dq_out), .dq_in(dram_dq_in),
    .rdata(cpu_rdata), .ack(cpu_ack), .cpu_wait(cpu_wait)
  );
endmodule

// File: rtl/dram_rowcol_chk.sv
module dram_rowcol_chk #(
  parameter int HALF_W = 10,
  parameter int T_PRE  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_ack,
  input logic              cpu_wait,
  input logic [HALF_W-1:0] dram_a,
  input logic              dram_ras_n,
  input logic              dram_cas_n,
  input logic              dram_we_n,
  input logic              dram_dq_oe
);
  localparam int HW = $clog2(T_PRE + 2) + 1;
  localparam logic [HW-1:0] SAT = HW'(T_PRE + 1);

  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst)              hi_cnt <= SAT;
    else if (!dram_ras_n) hi_cnt <= '0;
    else if (hi_cnt != SAT) hi_cnt <= hi_cnt + 1'b1;
  end

  // R2
  row_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!dram_ras_n && dram_cas_n && $past(!dram_ras_n)) |-> $stable(dram_a));

  // R3
  cas_in_ras_chk: assert property (@(posedge clk) disable iff (rst)
    !dram_cas_n |-> !dram_ras_n);

  // R4
  ack_single_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_ack |=> !cpu_ack);

  // R5
  we_in_cas_chk: assert property (@(posedge clk) disable iff (rst)
    !dram_we_n |-> (!dram_cas_n && dram_dq_oe));

  // R6
  precharge_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_ras_n) |-> (hi_cnt >= HW'(T_PRE)));

  // R9
  wait_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cpu_wait) |-> cpu_ack);

  // R9
  wait_ack_excl_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_wait |-> !cpu_ack);
endmodule

bind dram_rowcol_ctrl dram_rowcol_chk #(.HALF_W(HALF_W), .T_PRE(T_PRE)) u_chk (
  .clk(clk), .rst(rst), .cpu_ack(cpu_ack), .cpu_wait(cpu_wait),
  .dram_a(dram_a), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
  .dram_we_n(dram_we_n), .dram_dq_oe(dram_dq_oe)
);

// File: tb/tb_dram_rowcol_ctrl.sv
`timescale 1ns/1ps
module tb_dram_rowcol_ctrl;
  localparam int HALF_W = 10, DATA_W = 8;
  localparam int T_RAS = 2, T_CAS = 2, T_PRE = 2, T_REF = 3, REF_INTERVAL = 40;

  logic clk = 1'b0, rst = 1'b1;
  logic cpu_rd = 0, cpu_wr = 0;
  logic [2*HALF_W-1:0] cpu_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0, cpu_rdata, dram_dq_out;
  logic [DATA_W-1:0] dram_dq_in = '0;
  logic cpu_ack, cpu_wait, dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;
  logic [HALF_W-1:0] dram_a;

  always #10 clk = ~clk;

  dram_rowcol_ctrl #(.HALF_W(HALF_W), .DATA_W(DATA_W), .T_RAS(T_RAS), .T_CAS(T_CAS),
    .T_PRE(T_PRE), .T_REF(T_REF), .REF_INTERVAL(REF_INTERVAL)) dut (
    .clk(clk), .rst(rst), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack),
    .cpu_wait(cpu_wait), .dram_a(dram_a), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_dq_out(dram_dq_out),
    .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in));

  int n_chk = 0, n_err = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // memory model and strobe monitor
  logic [7:0] mem [int];
  logic prev_ras = 1, prev_cas = 1, cas_seen = 0, we_l = 1, oe_l = 0, wrap_seen = 0;
  logic [HALF_W-1:0] cur_row = '0, col_l = '0, last_ref_row = '0, first_ref_row = '1;
  logic [7:0] wd_l = '0;
  int ras_fall_cyc = 0, ras_rise_cyc = -1000, cas_delay = 0, min_gap = 1000;
  int n_ref = 0, ref_step_err = 0, ref_cas_err = 0, last_ref_start = 0, prev_ref_start = 0;
  int last_ref_end = 0;

  function automatic logic [7:0] fill(input int k);
    return k[7:0] ^ k[17:10];
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      if (prev_ras && !dram_ras_n) begin
        ras_fall_cyc = cyc; cur_row = dram_a; cas_seen = 0;
        if (cyc - ras_rise_cyc < min_gap) min_gap = cyc - ras_rise_cyc;
      end
      if (prev_cas && !dram_cas_n) begin
        int k;
        k = int'({cur_row, dram_a});
        cas_seen = 1; col_l = dram_a; we_l = dram_we_n; oe_l = dram_dq_oe;
        wd_l = dram_dq_out; cas_delay = cyc - ras_fall_cyc;
        if (!dram_we_n) mem[k] = dram_dq_out;
        else dram_dq_in = mem.exists(k) ? mem[k] : fill(k);
      end
      if (!dram_ras_n && dram_cas_n && cas_seen) ref_cas_err++;
      if (!prev_ras && dram_ras_n) begin
        ras_rise_cyc = cyc;
        if (!cas_seen) begin
          n_ref++;
          if (n_ref == 1) first_ref_row = cur_row;
          else if (cur_row != last_ref_row + 1'b1) ref_step_err++;
          if (n_ref > 1 && last_ref_row == '1 && cur_row == '0) wrap_seen = 1;
          last_ref_row = cur_row;
          prev_ref_start = last_ref_start; last_ref_start = ras_fall_cyc;
          last_ref_end = cyc;
        end
      end
      prev_ras = dram_ras_n; prev_cas = dram_cas_n;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one access; collide selects the expected wait behaviour
  task automatic access(input bit wr, input logic [19:0] addr, input logic [7:0] wd,
                        input logic [7:0] exp_rd, input bit collide);
    bit saw_wait = 0, got = 0;
    int req_cyc;
    cpu_rd = !wr; cpu_wr = wr; cpu_addr = addr; cpu_wdata = wd; req_cyc = cyc;
    @(negedge clk);
    cpu_rd = 0; cpu_wr = 0;
    if (collide) chk(cpu_wait == 1'b1, "R9 wait raised", cpu_wait, 1);
    for (int i = 0; i < 100 && !got; i++) begin
      if (cpu_ack) got = 1;
      else begin
        if (cpu_wait) saw_wait = 1;
        @(negedge clk);
      end
    end
    chk(got, "R4 ack seen", got, 1);
    chk(cpu_wait == 1'b0, "R9 wait low at ack", cpu_wait, 0);
    if (!collide) chk(saw_wait == 0, "R10 no wait", saw_wait, 0);
    else chk(ras_fall_cyc > last_ref_end, "R9 access after refresh", ras_fall_cyc, last_ref_end);
    chk(cur_row == addr[19:10], "R2 row address", cur_row, addr[19:10]);
    chk(cas_delay == T_RAS, "R2 row phase length", cas_delay, T_RAS);
    chk(col_l == addr[9:0], "R3 column address", col_l, addr[9:0]);
    if (wr) begin
      chk(we_l == 0 && oe_l == 1, "R5 write strobe", {we_l, oe_l}, 1);
      chk(wd_l == wd, "R5 write data", wd_l, wd);
    end else begin
      chk(we_l == 1, "R5 read keeps we high", we_l, 1);
      chk(cpu_rdata == exp_rd, "R4 read data", cpu_rdata, exp_rd);
    end
    @(negedge clk);
    chk(cpu_ack == 0, "R4 ack one cycle", cpu_ack, 0);
  endtask

  task automatic sync_after_refresh();
    int n0 = n_ref;
    for (int i = 0; i < 200 && n_ref == n0; i++) @(negedge clk);
    repeat (T_PRE + 2) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_we_n, "R1 strobes idle", {dram_ras_n, dram_cas_n, dram_we_n}, 7);
    chk(!dram_dq_oe && !cpu_ack && !cpu_wait, "R1 control low", {dram_dq_oe, cpu_ack, cpu_wait}, 0);
    chk(dram_a == '0, "R1 address zero", dram_a, 0);
  endtask

  task automatic t_basic();
    sync_after_refresh(); access(1, 20'hA5C3F, 8'h3C, 8'h00, 0);
    sync_after_refresh(); access(0, 20'hA5C3F, 8'h00, 8'h3C, 0);
    sync_after_refresh(); access(1, 20'hFFFFF, 8'hE1, 8'h00, 0);
    sync_after_refresh(); access(0, 20'hFFFFF, 8'h00, 8'hE1, 0);
    sync_after_refresh(); access(0, 20'h00401, 8'h00, fill(32'h00401), 0);
  endtask

  task automatic t_collide();
    sync_after_refresh();
    access(1, 20'h12345, 8'h77, 8'h00, 0);
    for (int i = 0; i < 200 && !(dram_ras_n == 0 && dram_cas_n == 1); i++) @(negedge clk);
    access(0, 20'h12345, 8'h00, 8'h77, 1);
  endtask

  task automatic t_period();
    int n0 = n_ref;
    for (int i = 0; i < 400 && n_ref < n0 + 3; i++) @(negedge clk);
    chk(last_ref_start - prev_ref_start == REF_INTERVAL, "R8 refresh spacing",
        last_ref_start - prev_ref_start, REF_INTERVAL);
    chk(last_ref_end - last_ref_start == T_REF, "R7 refresh length",
        last_ref_end - last_ref_start, T_REF);
    chk(ref_cas_err == 0, "R7 cas high in refresh", ref_cas_err, 0);
    chk(min_gap >= T_PRE, "R6 precharge gap", min_gap, T_PRE);
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 60000 && n_ref < 1030; i++) @(negedge clk);
    chk(first_ref_row == '0, "R7 first refresh row", first_ref_row, 0);
    chk(wrap_seen == 1, "R7 row counter wrap", wrap_seen, 1);
    chk(ref_step_err == 0, "R7 row step", ref_step_err, 0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk); rst = 0;
    t_basic();
    t_collide();
    t_period();
    t_wrap();
    finish_run();
  end
endmodule